// File: doc/BRIEF.md
# I2C Command-Word Byte Engine

This block runs an I2C bus as a master, one byte at a time. Software steers it through a single 16-bit command word. Each write of that word does three things. It supplies a byte to send. It sets the level that the engine drives in the acknowledge slot when it receives. It may also ask for a start, a repeated start or a stop. The engine shifts the byte onto SDA and generates SCL. The ninth clock is the acknowledge slot: the engine either samples it or drives it.

When a byte completes, the engine parks with SCL pulled low and raises its interrupt. It stays parked until software writes the word again, and that write is what releases the clock. Both bus lines are open-drain. The engine only ever pulls a line low or lets it go. SCL high and low phases each last `HALF_CYC` clock cycles.

A two-bit request field selects the next action. Its meaning depends on the current bus mode. The mode is reported on `mode` with this encoding:

| Code | Mode |
|------|------|
| 0 | slave receiver |
| 1 | master transmitter |
| 2 | master receiver |
| 3 | stopping |

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, `rd_data` reads 0, `irq` is 0, `mode` is 0 (slave receiver), and neither `scl_oe` nor `sda_oe` pulls its line.
- R2: The command word is accepted only when `wr_en` is high and `wr_be` is 2'b11. Any other `wr_be` leaves the stored word, the mode and the bus untouched. The readback layout is: bit 10 start request, bit 9 stop request, bit 8 acknowledge level, bits 7:0 data. Bits 15:11 always read 0.
- R3: A write arriving while a byte, start or stop sequence is in progress is ignored. Only slave-receiver idle and the parked state take writes.
- R4: A write with both request bits equal (00 or 11) leaves the mode unchanged. In slave-receiver mode it causes no bus activity. In a master mode it moves one byte: as transmitter it sends bits 7:0, and as receiver it clocks in a byte from the slave.
- R5: A start request (bit 10 = 1, bit 9 = 0) in slave-receiver mode produces a START condition and then sends bits 7:0 as the address. The mode becomes 1 when bit 0 is 0, and 2 when bit 0 is 1.
- R6: A start request while parked in a master mode produces a repeated START and the address byte. The mode is chosen from bit 0 in the same way as in R5.
- R7: A stop request (bit 9 = 1, bit 10 = 0) while parked in a master mode shows mode 3 during the sequence. It ends with SDA rising while SCL is high, after which the mode is 0. In slave-receiver mode a stop request causes no bus activity.
- R8: Bytes are sent most significant bit first. SDA changes only while SCL is low, except for START (SDA falls with SCL high) and STOP (SDA rises with SCL high).
- R9: When transmitting, the engine releases SDA on the ninth clock and reports the sampled level on `ack_in` (0 = acknowledged). When receiving, it drives the stored acknowledge level on the ninth clock and presents the received byte on `rx_byte`.
- R10: After every byte, `irq` is 1 and SCL is held low until the next accepted write. That write clears `irq` on the following clock edge. No interrupt follows a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command word write strobe |
| wr_be | input | 2 | Byte enables of the write; both must be set |
| wr_data | input | 16 | Command word to write |
| rd_data | output | 16 | Stored command word readback |
| irq | output | 1 | Byte complete, engine parked |
| mode | output | 2 | Bus mode code |
| rx_byte | output | 8 | Last byte received as master receiver |
| ack_in | output | 1 | Acknowledge level sampled after a sent byte |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
A wrong sequencer state shows up on the bus within one half period. Examples are a clock that keeps running while parked, SDA moving while SCL is high, or a START or STOP that should not be there. The bench decodes the bus line by line and flags any such event against its expected list as soon as the event occurs. A wrong mode or transmit/receive choice shows up at the next byte, as a data or acknowledge mismatch, or as a wrong `mode` code after the interrupt. A register that takes a write it should refuse is caught at once on `rd_data`.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 11;
  localparam int BIT_STA = 10;
  localparam int BIT_STO = 9;
  localparam int BIT_ACK = 8;

  typedef enum logic [1:0] {
    MODE_SLV_RX  = 2'd0,
    MODE_MST_TX  = 2'd1,
    MODE_MST_RX  = 2'd2,
    MODE_STOPPED = 2'd3
  } bus_mode_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_STOP  = 2'd2
  } bus_op_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_RS, SQ_STA_A, SQ_STA_B, SQ_BLO, SQ_BHI,
    SQ_HOLD, SQ_STP_A, SQ_STP_B, SQ_STP_C
  } seq_e;

  // Request field: only the two mixed codes do something.
  function automatic bus_op_e decode_op(input logic sta, input logic sto);
    case ({sta, sto})
      2'b10:   return OP_START;
      2'b01:   return OP_STOP;
      default: return OP_NONE;
    endcase
  endfunction

  // Direction bit of the address byte picks the master mode.
  function automatic bus_mode_e mode_after_addr(input logic rw);
    return rw ? MODE_MST_RX : MODE_MST_TX;
  endfunction

  // 1 means pull SDA low in this sequencer step.
  function automatic logic sda_low(input seq_e st, input logic [3:0] idx,
                                   input logic xmit, input logic [7:0] txb,
                                   input logic ack_lvl);
    logic last;
    last = (idx == 4'(BYTE_W));
    case (st)
      SQ_STA_B, SQ_STP_A, SQ_STP_B: return 1'b1;
      SQ_BLO, SQ_BHI: begin
        if (xmit) return last ? 1'b0 : ~txb[3'(BYTE_W - 1) - idx[2:0]];
        else      return last ? ~ack_lvl : 1'b0;
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic scl_low(input seq_e st);
    return (st == SQ_RS) || (st == SQ_BLO) || (st == SQ_HOLD) || (st == SQ_STP_A);
  endfunction

endpackage

// File: rtl/i2c_half_tick.sv
module i2c_half_tick #(
  parameter int HALF_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LIM = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || tick)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_cmd_reg.sv
module i2c_cmd_reg
  import i2c_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_be,
  input  logic [15:0]       wr_data,
  input  logic              ready,
  output logic              accept,
  output logic [WORD_W-1:0] word_q
);
  logic full_word;
  logic unused_hi_bits;

  assign full_word      = (wr_be == 2'b11);
  assign accept         = wr_en && full_word && ready;
  assign unused_hi_bits = ^wr_data[15:WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n)      word_q <= '0;
    else if (accept) word_q <= wr_data[WORD_W-1:0];
  end

  // R2: partial-width writes never land
  p_partial_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full_word) |=> $stable(word_q));

  // R3: writes during a running sequence never land
  p_busy_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready) |=> $stable(word_q));
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              accept,
  input  logic [WORD_W-1:0] cmd,
  input  logic              sda_i,
  output logic              ready,
  output logic              parked,
  output bus_mode_e         mode,
  output logic [7:0]        rx_byte,
  output logic              ack_in,
  output logic              scl_pull,
  output logic              sda_pull
);
  localparam logic [3:0] LAST_IDX = 4'(BYTE_W);

  seq_e       st;
  logic [3:0] bit_idx;
  logic       xmit;
  logic [7:0] tx_q;
  logic       ack_lvl;
  logic [7:0] rx_sh;
  bus_op_e    op;

  // named events for the assertions
  logic start_launch, stop_launch, byte_done;

  assign op           = decode_op(cmd[BIT_STA], cmd[BIT_STO]);
  assign start_launch = accept && (op == OP_START);
  assign stop_launch  = accept && (op == OP_STOP) && (st == SQ_HOLD);
  assign byte_done    = tick && (st == SQ_BHI) && (bit_idx == LAST_IDX);

  assign ready    = (st == SQ_IDLE) || (st == SQ_HOLD);
  assign parked   = (st == SQ_HOLD);
  assign scl_pull = scl_low(st);
  assign sda_pull = sda_low(st, bit_idx, xmit, tx_q, ack_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      mode    <= MODE_SLV_RX;
      bit_idx <= '0;
      xmit    <= 1'b0;
      tx_q    <= '0;
      ack_lvl <= 1'b1;
      rx_sh   <= '0;
      rx_byte <= '0;
      ack_in  <= 1'b1;
    end else if (accept) begin
      tx_q    <= cmd[7:0];
      ack_lvl <= cmd[BIT_ACK];
      bit_idx <= '0;
      if (st == SQ_IDLE) begin
        if (op == OP_START) begin
          st   <= SQ_STA_A;
          xmit <= 1'b1;
          mode <= mode_after_addr(cmd[0]);
        end
      end else begin
        case (op)
          OP_START: begin
            st   <= SQ_RS;
            xmit <= 1'b1;
            mode <= mode_after_addr(cmd[0]);
          end
          OP_STOP: begin
            st   <= SQ_STP_A;
            mode <= MODE_STOPPED;
          end
          default: begin
            st   <= SQ_BLO;
            xmit <= (mode == MODE_MST_TX);
          end
        endcase
      end
    end else if (tick) begin
      case (st)
        SQ_RS:    st <= SQ_STA_A;
        SQ_STA_A: st <= SQ_STA_B;
        SQ_STA_B: st <= SQ_BLO;
        SQ_BLO:   st <= SQ_BHI;
        SQ_BHI: begin
          if (xmit) begin
            if (bit_idx == LAST_IDX) ack_in <= sda_i;
          end else if (bit_idx == LAST_IDX) begin
            rx_byte <= rx_sh;
          end else begin
            rx_sh <= {rx_sh[6:0], sda_i};
          end
          if (bit_idx == LAST_IDX) begin
            st <= SQ_HOLD;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            st      <= SQ_BLO;
          end
        end
        SQ_STP_A: st <= SQ_STP_B;
        SQ_STP_B: st <= SQ_STP_C;
        SQ_STP_C: begin
          st   <= SQ_IDLE;
          mode <= MODE_SLV_RX;
        end
        default: ;
      endcase
    end
  end

  // R8: SDA steady through every high phase of a data/ack clock
  p_sda_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_BHI && $past(st) == SQ_BHI) |-> $stable(sda_pull));

  // R5/R6: a start always lands in a master mode
  p_start_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_launch |=> (mode == MODE_MST_TX || mode == MODE_MST_RX));

  // R7: stop sequence shows the stopping code, then slave receiver
  p_stop_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_launch |=> (mode == MODE_STOPPED));
  p_stop_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_STP_C && tick) |=> (mode == MODE_SLV_RX && st == SQ_IDLE));

  // R10: a finished byte parks, and parking lasts until a write
  p_byte_parks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> parked);
  p_park_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !accept) |=> parked);
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int HALF_CYC = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        irq,
  output logic [1:0]  mode,
  output logic [7:0]  rx_byte,
  output logic        ack_in,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_i
);
  logic              accept;
  logic              ready;
  logic              tick;
  logic              parked;
  logic [WORD_W-1:0] word_q;
  bus_mode_e         mode_e;

  i2c_cmd_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .ready   (ready),
    .accept  (accept),
    .word_q  (word_q)
  );

  i2c_half_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .tick    (tick)
  );

  i2c_bit_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .accept   (accept),
    .cmd      (wr_data[WORD_W-1:0]),
    .sda_i    (sda_i),
    .ready    (ready),
    .parked   (parked),
    .mode     (mode_e),
    .rx_byte  (rx_byte),
    .ack_in   (ack_in),
    .scl_pull (scl_oe),
    .sda_pull (sda_oe)
  );

  assign rd_data = {{(16 - WORD_W){1'b0}}, word_q};
  assign irq     = parked;
  assign mode    = mode_e;

  // R10: clock stretched for as long as the interrupt stands
  p_stretch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_oe);

  // R10: an accepted write clears the interrupt on the next edge
  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && accept) |=> !irq);
endmodule

// File: tb/i2c_cmd_engine_tb_top.sv
module i2c_cmd_engine_tb_top;
  localparam int HALF = 6;
  localparam int EV_START = 1, EV_STOP = 2, EV_BYTE = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  logic [1:0]  mode;
  logic [7:0]  rx_byte;
  logic        ack_in;
  logic        scl_oe, sda_oe;
  logic        sda_i;

  i2c_cmd_engine #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .mode(mode), .rx_byte(rx_byte), .ack_in(ack_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  // bench slave: 0 = silent, 1 = acknowledges, 2 = sends slv_byte
  int         bs_mode = 0;
  logic [7:0] slv_byte = '0;
  int         idx = 15;
  logic       pull;
  logic       scl_line, sda_line;

  always_comb begin
    pull = 1'b0;
    if (bs_mode == 1 && idx == 8) pull = 1'b1;
    if (bs_mode == 2 && idx >= 0 && idx < 8) pull = ~slv_byte[7 - idx];
  end
  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | pull);
  assign sda_i    = sda_line;

  int n_chk = 0, n_fail = 0;
  logic [10:0] exp_q[$];

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input logic [7:0] b, input logic a);
    exp_q.push_back({kind[1:0], b, a});
  endtask

  task automatic got(input int kind, input logic [7:0] b, input logic a);
    logic [10:0] e;
    logic [10:0] seen;
    seen = {kind[1:0], b, a};
    if (exp_q.size() == 0) check(1'b0, "R8 unexpected bus event", seen, 0);
    else begin
      e = exp_q.pop_front();
      check(e == seen, "R8 bus event (kind,byte msb first,ack)", seen, e);
    end
  endtask

  // monitor: decodes the lines, pops the scoreboard
  logic       scl_p = 1'b1, sda_p = 1'b1;
  int         rises = 0;
  logic [8:0] sh = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_p && scl_line && sda_p && !sda_line) begin
        got(EV_START, 8'h00, 1'b0); rises = 0; idx = 15;
      end else if (scl_p && scl_line && !sda_p && sda_line) begin
        got(EV_STOP, 8'h00, 1'b0);
      end else if (!scl_p && scl_line) begin
        sh = {sh[7:0], sda_line};
        rises++;
        if (rises == 9) begin
          got(EV_BYTE, sh[8:1], sh[0]);
          rises = 0;
        end
      end else if (scl_p && !scl_line) begin
        idx = rises;
      end
    end
    scl_p = scl_line;
    sda_p = sda_line;
  end

  task automatic write_word(input logic [15:0] w, input logic [1:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic wait_slave_idle();
    while (mode != 2'd0) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 16'h0000, "R1 reset readback", rd_data, 0);
    check(irq == 1'b0 && mode == 2'd0, "R1 reset irq/mode", {irq, mode}, 0);
    check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

    // R2: byte-wide writes ignored
    write_word(16'h04A4, 2'b01);
    write_word(16'h04A4, 2'b10);
    repeat (40) @(negedge clk);
    check(rd_data == 16'h0000, "R2 partial write ignored", rd_data, 0);
    check(mode == 2'd0 && !scl_oe, "R2 partial write no start", {mode, scl_oe}, 0);

    // R7: stop request in slave receiver: nothing on the bus
    write_word(16'h0233, 2'b11);
    repeat (40) @(negedge clk);
    check(rd_data == 16'h0233, "R2 full write readback layout", rd_data, 16'h0233);
    check(mode == 2'd0 && !scl_oe && !sda_oe && !irq, "R7 stop in slave receiver idle",
          {mode, scl_oe, sda_oe, irq}, 0);

    // R4 and R2: both request bits set, read-only bits read 0
    write_word(16'hFE12, 2'b11);
    repeat (40) @(negedge clk);
    check(rd_data == 16'h0612, "R2 read-only bits read zero", rd_data, 16'h0612);
    check(mode == 2'd0 && !scl_oe && !sda_oe, "R4 11 code in slave receiver idle",
          {mode, scl_oe, sda_oe}, 0);

    // R5: start, address with direction 0
    bs_mode = 1;
    expect_ev(EV_START, 8'h00, 1'b0);
    expect_ev(EV_BYTE, 8'hA4, 1'b0);
    write_word(16'h04A4, 2'b11);
    repeat (20) @(negedge clk);
    write_word(16'h0200, 2'b11);
    check(rd_data == 16'h04A4, "R3 write during transfer ignored", rd_data, 16'h04A4);
    wait_irq();
    check(mode == 2'd1, "R5 start to master transmitter", mode, 1);
    check(ack_in == 1'b0, "R9 address acknowledged", ack_in, 0);
    repeat (60) @(negedge clk);
    check(irq && scl_oe, "R10 SCL stretched while parked", {irq, scl_oe}, 2'b11);
    write_word(16'h0200, 2'b10);
    repeat (10) @(negedge clk);
    check(irq && scl_oe && mode == 2'd1, "R2 partial write while parked ignored",
          {irq, scl_oe, mode}, {2'b11, 2'd1});

    // R4: 00 in master transmitter sends a byte, slave refuses it
    bs_mode = 0;
    expect_ev(EV_BYTE, 8'h3C, 1'b1);
    write_word(16'h013C, 2'b11);
    check(irq == 1'b0, "R10 write clears irq", irq, 0);
    wait_irq();
    check(ack_in == 1'b1, "R9 not-acknowledge sampled", ack_in, 1);
    check(mode == 2'd1, "R4 00 code keeps master transmitter", mode, 1);

    // R4: 11 also just moves a byte
    bs_mode = 1;
    expect_ev(EV_BYTE, 8'h81, 1'b0);
    write_word(16'h0781, 2'b11);
    wait_irq();
    check(mode == 2'd1 && ack_in == 1'b0, "R4 11 code keeps master transmitter",
          {mode, ack_in}, {2'd1, 1'b0});

    // R6: repeated start, direction 1
    expect_ev(EV_START, 8'h00, 1'b0);
    expect_ev(EV_BYTE, 8'hA5, 1'b0);
    write_word(16'h04A5, 2'b11);
    wait_irq();
    check(mode == 2'd2, "R6 repeated start to master receiver", mode, 2);

    // R9: receive with acknowledge level 0
    bs_mode = 2; slv_byte = 8'h96;
    expect_ev(EV_BYTE, 8'h96, 1'b0);
    write_word(16'h0000, 2'b11);
    wait_irq();
    check(rx_byte == 8'h96, "R9 received byte", rx_byte, 8'h96);
    check(mode == 2'd2, "R4 00 code keeps master receiver", mode, 2);

    // R9: receive with acknowledge level 1
    slv_byte = 8'h5A;
    expect_ev(EV_BYTE, 8'h5A, 1'b1);
    write_word(16'h0100, 2'b11);
    wait_irq();
    check(rx_byte == 8'h5A, "R9 received byte, nack driven", rx_byte, 8'h5A);

    // R7: stop from master receiver
    bs_mode = 0;
    expect_ev(EV_STOP, 8'h00, 1'b0);
    write_word(16'h0200, 2'b11);
    check(mode == 2'd3, "R7 stopping mode shown", mode, 3);
    wait_slave_idle();
    repeat (40) @(negedge clk);
    check(!irq && !scl_oe && !sda_oe, "R7 R10 idle after stop, no irq",
          {irq, scl_oe, sda_oe}, 0);

    // R5 again from idle, then stop from master transmitter
    bs_mode = 1;
    expect_ev(EV_START, 8'h00, 1'b0);
    expect_ev(EV_BYTE, 8'h50, 1'b0);
    write_word(16'h0450, 2'b11);
    wait_irq();
    check(mode == 2'd1, "R5 second start to master transmitter", mode, 1);
    bs_mode = 0;
    expect_ev(EV_STOP, 8'h00, 1'b0);
    write_word(16'h0250, 2'b11);
    wait_slave_idle();
    repeat (20) @(negedge clk);
    check(mode == 2'd0 && !irq, "R7 back to slave receiver", {mode, irq}, 0);
    check(exp_q.size() == 0, "R8 all expected bus events seen", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule